// File: doc/BRIEF.md
# SPI Mode Fault Supervisor

This block guards an SPI port against output driver contention. It compares the slave-select input with the role that the mode controls select. It also watches a transfer-active flag from the shift engine. When the two sides disagree, the block latches a fault. The fault takes the port off the clock, MOSI and MISO lines. It also raises a one-cycle receive interrupt.

Software clears the fault in one way only. It writes the 3-bit serial I/O mode field to zero while the receiver enable is low. After the clear, the port goes back to the master role. The exception is when the CTS-select control was set at the moment of the clear. In that case the port stays a slave until SPI is disabled.

The raw slave-select pin passes through a two-stage synchronizer before any comparison. When no pin is assigned to the slave-select function, the block makes up a select level of its own and detection is off. The shifting itself and the baud generation sit outside this block.

Top module: `spi_mode_fault`

## Requirements
- R1: When `spi_en_i` is 0, both role outputs and all three output enables are 0. When `spi_en_i`=1, `clk_dir_i`=1, no fault is latched and no slave hold is active, the role is master: `role_master_o`=1, `clk_oe_o`=1 and `mosi_oe_o`=1. In every other case with `spi_en_i`=1, the role is slave: `role_slave_o`=1. The two role outputs are never 1 together.
- R2: `ss_pin_i` (active low) passes through two synchronizer flops. A change on the pin can raise a fault at the third rising clock edge after the change, and no earlier.
- R3: In the master role, with a pin assigned, a synchronized select level of 0 sets the fault at the next edge.
- R4: In the slave role, with a pin assigned, a synchronized select level of 1 while `xfer_active_i`=1 sets the fault at the next edge. A select level of 1 with `xfer_active_i`=0 does not set it.
- R5: While `fault_o`=1, `clk_oe_o`, `mosi_oe_o` and `miso_oe_o` are all 0, and the role is slave (when `spi_en_i`=1).
- R6: `fault_o` is sticky. `rx_irq_o` is 1 for exactly the one cycle in which `fault_o` first becomes 1.
- R7: A latched fault clears at the next edge only when `sio_mode_i`==3'b000 and `rx_en_i`=0 hold together. Any other combination keeps it set.
- R8: After a clear with `cts_sel_i`=0, the master role returns at once if `clk_dir_i`=1. After a clear with `cts_sel_i`=1, the slave role is held until `spi_en_i` is 0 for one edge.
- R9: With `ss_assigned_i`=0, no fault is ever raised. In that case the internal select is negated in the master role and asserted in the slave role.
- R10: With `spi_en_i`=0, no fault is raised, whatever the pin and transfer inputs do.
- R11: `miso_oe_o` is 1 only in the slave role, with no fault latched and the effective select asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_en_i | input | 1 | SPI mode enable |
| clk_dir_i | input | 1 | Clock direction: 1 = internal clock (master) |
| sio_mode_i | input | 3 | Serial I/O mode field; 000 is part of the clear sequence |
| rx_en_i | input | 1 | Receiver enable |
| ss_assigned_i | input | 1 | Slave-select function is mapped to a pin |
| cts_sel_i | input | 1 | CTS-select control; set at clear keeps slave role |
| ss_pin_i | input | 1 | Raw slave-select pin, active low, asynchronous |
| xfer_active_i | input | 1 | Shift engine has a transfer in progress |
| role_master_o | output | 1 | Effective role is master |
| role_slave_o | output | 1 | Effective role is slave |
| clk_oe_o | output | 1 | Drive enable for the serial clock |
| mosi_oe_o | output | 1 | Drive enable for MOSI |
| miso_oe_o | output | 1 | Drive enable for MISO |
| fault_o | output | 1 | Sticky mode fault status |
| rx_irq_o | output | 1 | One-cycle receive interrupt on fault entry |

## Verification
A control input affects the role and enable outputs within the same cycle. It affects the fault state at the next edge. A pin edge needs three edges before `fault_o` and `rx_irq_o` respond. The bench drives every input just after a falling clock edge. It compares all seven outputs at the next falling edge against a cycle model that is advanced on each rising edge. In this way each output is sampled after exactly the number of edges it needs. The directed cases wait out the two synchronizer edges before they expect a fault, and they check that nothing shows up earlier.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int unsigned SIO_MODE_W = 3;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_mf_role.sv
module spi_mf_role
  import spi_mf_pkg::*;
(
  input  logic  spi_en_i,
  input  logic  clk_dir_i,
  input  logic  fault_i,
  input  logic  hold_slave_i,
  input  logic  ss_assigned_i,
  input  logic  ss_sync_i,
  output role_e role_o,
  output logic  ss_sel_o
);
  always_comb begin
    if (!spi_en_i)                                   role_o = ROLE_OFF;
    else if (clk_dir_i && !fault_i && !hold_slave_i) role_o = ROLE_MASTER;
    else                                             role_o = ROLE_SLAVE;
  end

  // unassigned pin: negated as master, selected as slave
  assign ss_sel_o = ss_assigned_i ? ~ss_sync_i : (role_o == ROLE_SLAVE);
endmodule

// File: rtl/spi_mf_fault.sv
module spi_mf_fault
  import spi_mf_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  spi_en_i,
  input  logic                  ss_assigned_i,
  input  role_e                 role_i,
  input  logic                  ss_sel_i,
  input  logic                  xfer_active_i,
  input  logic [SIO_MODE_W-1:0] sio_mode_i,
  input  logic                  rx_en_i,
  input  logic                  cts_sel_i,
  output logic                  fault_o,
  output logic                  irq_o,
  output logic                  hold_slave_o
);
  logic fault_q, irq_q, hold_q;
  logic det, clr;

  always_comb begin
    det = spi_en_i && ss_assigned_i && !fault_q &&
          (((role_i == ROLE_MASTER) && ss_sel_i) ||
           ((role_i == ROLE_SLAVE) && xfer_active_i && !ss_sel_i));
    clr = fault_q && (sio_mode_i == '0) && !rx_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      irq_q   <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      irq_q <= det;
      if (det)      fault_q <= 1'b1;
      else if (clr) fault_q <= 1'b0;
      if (clr && cts_sel_i) hold_q <= 1'b1;
      else if (!spi_en_i)   hold_q <= 1'b0;
    end
  end

  assign fault_o      = fault_q;
  assign irq_o        = irq_q;
  assign hold_slave_o = hold_q;

  p_irq_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  p_irq_on_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $rose(fault_q));
  p_fault_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q && !((sio_mode_i == '0) && !rx_en_i) |=> fault_q);
  p_fault_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q && (sio_mode_i == '0) && !rx_en_i |=> !fault_q);
  p_no_eval_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_en_i && !fault_q |=> !fault_q);
  p_no_eval_unassigned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_assigned_i && !fault_q |=> !fault_q);
endmodule

// File: rtl/spi_mode_fault.sv
module spi_mode_fault
  import spi_mf_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  spi_en_i,
  input  logic                  clk_dir_i,
  input  logic [SIO_MODE_W-1:0] sio_mode_i,
  input  logic                  rx_en_i,
  input  logic                  ss_assigned_i,
  input  logic                  cts_sel_i,
  input  logic                  ss_pin_i,
  input  logic                  xfer_active_i,
  output logic                  role_master_o,
  output logic                  role_slave_o,
  output logic                  clk_oe_o,
  output logic                  mosi_oe_o,
  output logic                  miso_oe_o,
  output logic                  fault_o,
  output logic                  rx_irq_o
);
  logic  ss_sync, ss_sel, fault, hold_slave;
  role_e role;

  spi_mf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ss_pin_i),
    .q_o   (ss_sync)
  );

  spi_mf_role i_role (
    .spi_en_i     (spi_en_i),
    .clk_dir_i    (clk_dir_i),
    .fault_i      (fault),
    .hold_slave_i (hold_slave),
    .ss_assigned_i(ss_assigned_i),
    .ss_sync_i    (ss_sync),
    .role_o       (role),
    .ss_sel_o     (ss_sel)
  );

  spi_mf_fault i_fault (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .spi_en_i     (spi_en_i),
    .ss_assigned_i(ss_assigned_i),
    .role_i       (role),
    .ss_sel_i     (ss_sel),
    .xfer_active_i(xfer_active_i),
    .sio_mode_i   (sio_mode_i),
    .rx_en_i      (rx_en_i),
    .cts_sel_i    (cts_sel_i),
    .fault_o      (fault),
    .irq_o        (rx_irq_o),
    .hold_slave_o (hold_slave)
  );

  assign role_master_o = (role == ROLE_MASTER);
  assign role_slave_o  = (role == ROLE_SLAVE);
  assign clk_oe_o      = role_master_o;
  assign mosi_oe_o     = role_master_o;
  assign miso_oe_o     = role_slave_o && ss_sel && !fault;
  assign fault_o       = fault;

  p_role_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(role_master_o && role_slave_o));
  p_fault_drivers_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !clk_oe_o && !mosi_oe_o && !miso_oe_o);
  p_fault_slave_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && spi_en_i |-> role_slave_o);
  p_miso_slave_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> role_slave_o && !fault_o);
endmodule

// File: tb/test_spi_mode_fault.sv
`timescale 1ns/1ps
module test_spi_mode_fault;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_en = 0, clk_dir = 0, rx_en = 0, ss_asg = 0, cts = 0, ss_pin = 1, xfer = 0;
  logic [2:0] sio = 3'd0;
  logic rm, rs, coe, moe, soe, flt, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_mode_fault i_spi_mode_fault (
    .clk_i(clk), .rst_ni(rst_n), .spi_en_i(spi_en), .clk_dir_i(clk_dir),
    .sio_mode_i(sio), .rx_en_i(rx_en), .ss_assigned_i(ss_asg), .cts_sel_i(cts),
    .ss_pin_i(ss_pin), .xfer_active_i(xfer), .role_master_o(rm), .role_slave_o(rs),
    .clk_oe_o(coe), .mosi_oe_o(moe), .miso_oe_o(soe), .fault_o(flt), .rx_irq_o(irq));

  // cycle model built from the requirements
  logic m_s1 = 1, m_s2 = 1, m_fault = 0, m_irq = 0, m_hold = 0;

  function automatic logic [1:0] mrole();
    if (!spi_en) return 2'd0;
    if (clk_dir && !m_fault && !m_hold) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic msel(logic [1:0] r);
    return ss_asg ? !m_s2 : (r == 2'd2);
  endfunction

  function automatic logic [6:0] mexp();
    logic [1:0] r;
    r = mrole();
    return {r == 2'd1, r == 2'd2, r == 2'd1, r == 2'd1,
            (r == 2'd2) && msel(r) && !m_fault, m_fault, m_irq};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1; m_s2 <= 1; m_fault <= 0; m_irq <= 0; m_hold <= 0;
    end else begin : upd
      logic [1:0] r;
      logic sel, det, clr;
      r   = mrole();
      sel = msel(r);
      det = spi_en && ss_asg && !m_fault && ((r == 2'd1 && sel) || (r == 2'd2 && xfer && !sel));
      clr = m_fault && sio == 3'd0 && !rx_en;
      m_s1 <= ss_pin; m_s2 <= m_s1; m_irq <= det;
      if (det) m_fault <= 1; else if (clr) m_fault <= 0;
      if (clr && cts) m_hold <= 1; else if (!spi_en) m_hold <= 0;
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmp_all(string tag);
    logic [6:0] e;
    e = mexp();
    checks++;
    if ({rm, rs, coe, moe, soe, flt, irq} !== e) begin
      fails++;
      $display("FAIL %s: outputs got %b expected %b at %0t", tag,
               {rm, rs, coe, moe, soe, flt, irq}, e, $time);
    end
  endtask

  task automatic step(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      cmp_all(tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    #7 rst_n = 1;
    @(negedge clk);
    cmp_all("R1 reset");
    chk("R1 reset role", rm | rs | coe | soe, 1'b0);
    chk("R6 reset fault", flt, 1'b0);

    // master, pin assigned, select negated
    spi_en = 1; clk_dir = 1; ss_asg = 1; rx_en = 1; sio = 3'd1;
    step(1, "R1 master");
    chk("R1 master clk_oe", coe, 1'b1);
    chk("R1 master mosi_oe", moe, 1'b1);

    ss_pin = 0;
    step(2, "R2 sync delay");
    chk("R2 no early fault", flt, 1'b0);
    step(1, "R3 master fault");
    chk("R3 fault set", flt, 1'b1);
    chk("R6 irq on entry", irq, 1'b1);
    chk("R5 clk_oe off", coe, 1'b0);
    chk("R5 slave role", rs, 1'b1);
    step(1, "R6 irq pulse");
    chk("R6 irq single", irq, 1'b0);
    chk("R6 sticky", flt, 1'b1);

    ss_pin = 1; sio = 3'd0;
    step(3, "R7 rx_en still set");
    chk("R7 not cleared", flt, 1'b1);
    sio = 3'd4; rx_en = 0;
    step(1, "R7 mode nonzero");
    chk("R7 not cleared mode", flt, 1'b1);
    sio = 3'd0;
    step(1, "R7 clear");
    chk("R7 cleared", flt, 1'b0);
    chk("R8 master back", rm, 1'b1);

    // second fault, cleared with cts_sel set
    sio = 3'd1; rx_en = 1; ss_pin = 0;
    step(3, "R3 refault");
    chk("R3 refault", flt, 1'b1);
    ss_pin = 1; cts = 1;
    step(2, "R7 wait");
    sio = 3'd0; rx_en = 0;
    step(1, "R8 cts clear");
    chk("R8 held slave", rs, 1'b1);
    chk("R8 not master", rm, 1'b0);
    cts = 0;
    step(2, "R8 hold stays");
    chk("R8 hold persists", rm, 1'b0);
    spi_en = 0;
    step(1, "R8 disable");
    spi_en = 1;
    step(1, "R8 master again");
    chk("R8 master after disable", rm, 1'b1);

    // slave role
    clk_dir = 0; ss_pin = 0; rx_en = 1; sio = 3'd1;
    step(2, "R11 select");
    chk("R11 miso_oe", soe, 1'b1);
    ss_pin = 1;
    step(2, "R4 idle");
    chk("R4 no fault idle", flt, 1'b0);
    chk("R11 deselected", soe, 1'b0);
    xfer = 1;
    step(1, "R4 slave fault");
    chk("R4 fault", flt, 1'b1);
    chk("R5 miso off", soe, 1'b0);
    xfer = 0; sio = 3'd0; rx_en = 0;
    step(1, "R7 clear slave");

    // unassigned pin
    ss_asg = 0; clk_dir = 1; ss_pin = 0; sio = 3'd1; rx_en = 1;
    step(5, "R9 master unassigned");
    chk("R9 no fault", flt, 1'b0);
    clk_dir = 0; xfer = 1; ss_pin = 1;
    step(5, "R9 slave unassigned");
    chk("R9 slave selected", soe, 1'b1);
    chk("R9 no fault slave", flt, 1'b0);

    // SPI disabled
    spi_en = 0; ss_asg = 1; clk_dir = 1; ss_pin = 0;
    step(5, "R10 disabled");
    chk("R10 no fault", flt, 1'b0);
    chk("R1 off miso", soe, 1'b0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) spi_en  = ~spi_en;
      if ($urandom_range(7) == 0) clk_dir = ~clk_dir;
      if ($urandom_range(9) == 0) ss_asg  = ~ss_asg;
      if ($urandom_range(5) == 0) cts     = $urandom_range(1);
      if ($urandom_range(3) == 0) ss_pin  = ~ss_pin;
      if ($urandom_range(3) == 0) xfer    = $urandom_range(1);
      if ($urandom_range(3) == 0) rx_en   = $urandom_range(1);
      if ($urandom_range(3) == 0) sio     = ($urandom_range(1) == 0) ? 3'd0 : 3'($urandom_range(7));
      step(1, "RND");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule